// File: doc/BRIEF.md
# Multi-Polynomial CRC Generator Engine

This block keeps a running cyclic redundancy checksum over data words written into it through a small memory-mapped port. Software programs a control word to pick one of four polynomials (16-bit CCITT, 8-bit, 16-bit and 32-bit). The same control word sets optional transforms on the data going in and on the checksum coming out. A seed word gives the starting value. Each data write carries 1, 2 or 4 bytes, and the engine folds all of them into the state in the same clock cycle.

There are four word-addressed registers. Address 0 is control, 1 is seed, 2 is the data port and 3 is the checksum. Writes take effect at the clock edge where `wr_en` is high. A read issued with `rd_en` returns its value on `rd_data` one cycle later, from a registered output. The CRC runs MSB-first and is not reflected. Within a write, byte lane 0 (`wr_data[7:0]`) is folded in first, then lane 1, and so on.

Top module: `crcgen_top`

## Requirements
- R1: Register map: address 0 is control, 1 is seed, 2 is the data port, 3 is the checksum. Reads return on `rd_data` one cycle after `rd_en`. Control keeps only bits [31:30], [27:24] and [0], and all other bits read as zero (the reload bit 1 included). The seed reads back as written, and the data port reads zero.
- R2: When control bit 0 (enable) is clear, a write to the data port leaves the CRC state unchanged.
- R3: Writing the seed register loads the seed, masked to the active CRC width, into the CRC state in the same cycle.
- R4: Writing control with bit 1 set reloads the stored seed into the CRC state, masked to the width of the newly written mode.
- R5: Mode field control[31:30] = 3 selects the 32-bit polynomial 0x04C11DB7. With seed 0, the single byte 0x01 gives 0x04C11DB7.
- R6: Mode 2 selects the 16-bit polynomial 0x8005. With seed 0, byte 0x01 gives 0x8005.
- R7: Mode 0 selects the 16-bit CCITT polynomial 0x1021. With seed 0, byte 0x01 gives 0x1021.
- R8: Mode 1 selects the 8-bit polynomial 0x07. With seed 0, byte 0x01 gives 0x07.
- R9: `wr_size` 0, 1 and 2 (and 3) fold 1, 2 and 4 bytes starting at lane 0, all in one cycle. Lanes beyond the size are ignored.
- R10: Control bit 26 inverts every write-data bit before the CRC update.
- R11: Control bit 24 reverses bit order inside each byte of the write data (not across the word) before the CRC update.
- R12: Control bit 27 makes the checksum readback the one's complement of the state within the active width. It never alters the stored state.
- R13: Control bit 25 reverses the checksum readback across the active width only. Checksum bits above the active width always read zero.
- R14: After reset, control, seed and checksum all read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 32 | Write data |
| wr_size | input | 2 | Data write size: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 32 | Registered read data, valid one cycle after rd_en |

## Verification
A vector table runs each polynomial with all-ones, zero and non-trivial seeds, at all three write sizes, under different mixes of the four transforms. Results are compared with a reference model in the bench. The model separates per-byte reversal from whole-word reversal, and lane order from the lane count. Hand-derived single-byte cases (byte 0x01 from seed 0 gives exactly the polynomial) pin each polynomial value and width apart from the model. Variants of those same cases isolate input complement, per-byte reversal, output complement, width-limited output reversal and size truncation. Directed cases cover disabled writes, seed reload, and output transforms switched off again, which shows the stored state was never touched.

// File: rtl/crcgen_pkg.sv
package crcgen_pkg;

  typedef enum logic [1:0] {
    POLY_CCITT = 2'd0,
    POLY_CRC8  = 2'd1,
    POLY_CRC16 = 2'd2,
    POLY_CRC32 = 2'd3
  } poly_sel_e;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_SEED = 2'd1;
  localparam logic [1:0] REG_DATA = 2'd2;
  localparam logic [1:0] REG_CSUM = 2'd3;

  localparam int CB_EN      = 0;
  localparam int CB_RELOAD  = 1;
  localparam int CB_IN_REV  = 24;
  localparam int CB_OUT_REV = 25;
  localparam int CB_IN_INV  = 26;
  localparam int CB_OUT_INV = 27;

  localparam logic [31:0] CTRL_KEEP = 32'hCF00_0001;

  function automatic logic [31:0] width_mask(poly_sel_e m);
    case (m)
      POLY_CRC8:  return 32'h0000_00FF;
      POLY_CRC32: return 32'hFFFF_FFFF;
      default:    return 32'h0000_FFFF;
    endcase
  endfunction

  function automatic logic [5:0] width_bits(poly_sel_e m);
    case (m)
      POLY_CRC8:  return 6'd8;
      POLY_CRC32: return 6'd32;
      default:    return 6'd16;
    endcase
  endfunction

  function automatic logic [31:0] poly_value(poly_sel_e m);
    case (m)
      POLY_CCITT: return 32'h0000_1021;
      POLY_CRC8:  return 32'h0000_0007;
      POLY_CRC16: return 32'h0000_8005;
      default:    return 32'h04C1_1DB7;
    endcase
  endfunction

  function automatic logic [7:0] flip8(logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

endpackage

// File: rtl/crcgen_in_xform.sv
module crcgen_in_xform #(
  parameter int LANES = 4,
  localparam int DW = LANES * 8
) (
  input  logic [DW-1:0] din,
  input  logic          inv,
  input  logic          rev,
  output logic [DW-1:0] dout
);
  import crcgen_pkg::*;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] b;
    always_comb begin
      b = inv ? ~din[g*8 +: 8] : din[g*8 +: 8];
      dout[g*8 +: 8] = rev ? flip8(b) : b;
    end
  end
endmodule

// File: rtl/crcgen_lane_chain.sv
module crcgen_lane_chain #(
  parameter int LANES = 4,
  localparam int DW = LANES * 8,
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic [31:0]           state,
  input  logic [DW-1:0]         data,
  input  logic [CW-1:0]         nbytes,
  input  crcgen_pkg::poly_sel_e mode,
  output logic [31:0]           next
);
  import crcgen_pkg::*;

  function automatic logic [31:0] fold_byte(logic [31:0] s_in, logic [7:0] d,
                                            poly_sel_e m);
    logic [31:0] s, msk, top, p;
    logic fb;
    msk = width_mask(m);
    top = (msk >> 1) + 32'd1;
    p   = poly_value(m);
    s   = s_in & msk;
    for (int k = 7; k >= 0; k--) begin
      fb = ((s & top) != 32'd0) ^ d[k];
      s  = (s << 1) & msk;
      if (fb) s = s ^ p;
    end
    return s;
  endfunction

  logic [31:0] stage [LANES+1];
  assign stage[0] = state;

  for (genvar g = 0; g < LANES; g++) begin : g_step
    always_comb begin
      if (CW'(g) < nbytes) stage[g+1] = fold_byte(stage[g], data[g*8 +: 8], mode);
      else                 stage[g+1] = stage[g];
    end
  end

  assign next = stage[LANES];
endmodule

// File: rtl/crcgen_out_xform.sv
module crcgen_out_xform (
  input  logic [31:0]           state,
  input  crcgen_pkg::poly_sel_e mode,
  input  logic                  inv,
  input  logic                  rev,
  output logic [31:0]           csum
);
  import crcgen_pkg::*;

  logic [31:0] msk, v, flipped;
  logic [5:0]  sh;

  always_comb begin
    msk = width_mask(mode);
    sh  = 6'd32 - width_bits(mode);
    v   = inv ? (~state & msk) : (state & msk);
    for (int i = 0; i < 32; i++) flipped[i] = v[31-i];
    csum = rev ? (flipped >> sh) : v;
  end
endmodule

// File: rtl/crcgen_top.sv
module crcgen_top #(
  parameter int LANES = 4,
  localparam int DW = LANES * 8,
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    wr_size,
  input  logic          rd_en,
  input  logic [1:0]    rd_addr,
  output logic [DW-1:0] rd_data
);
  import crcgen_pkg::*;

  logic [31:0] ctrl_q, seed_q, crc_q;
  poly_sel_e   mode, new_mode;
  logic [DW-1:0] data_x;
  logic [31:0] crc_next, csum;
  logic [CW-1:0] nbytes;

  assign mode     = poly_sel_e'(ctrl_q[31:30]);
  assign new_mode = poly_sel_e'(wr_data[31:30]);

  always_comb begin
    case (wr_size)
      2'd0:    nbytes = CW'(1);
      2'd1:    nbytes = CW'(2);
      default: nbytes = CW'(LANES);
    endcase
  end

  crcgen_in_xform #(.LANES(LANES)) in_x_i (
    .din(wr_data), .inv(ctrl_q[CB_IN_INV]), .rev(ctrl_q[CB_IN_REV]), .dout(data_x)
  );

  crcgen_lane_chain #(.LANES(LANES)) chain_i (
    .state(crc_q), .data(data_x), .nbytes(nbytes), .mode(mode), .next(crc_next)
  );

  crcgen_out_xform out_x_i (
    .state(crc_q), .mode(mode), .inv(ctrl_q[CB_OUT_INV]),
    .rev(ctrl_q[CB_OUT_REV]), .csum(csum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      seed_q <= '0;
      crc_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        REG_CTRL: begin
          ctrl_q <= wr_data[31:0] & CTRL_KEEP;
          if (wr_data[CB_RELOAD]) crc_q <= seed_q & width_mask(new_mode);
        end
        REG_SEED: begin
          seed_q <= wr_data[31:0];
          crc_q  <= wr_data[31:0] & width_mask(mode);
        end
        REG_DATA: if (ctrl_q[CB_EN]) crc_q <= crc_next;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) begin
      case (rd_addr)
        REG_CTRL: rd_data <= DW'(ctrl_q);
        REG_SEED: rd_data <= DW'(seed_q);
        REG_CSUM: rd_data <= DW'(csum);
        default:  rd_data <= '0;
      endcase
    end
  end

  // R2: disabled data writes keep the state
  assert_disabled_write_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == REG_DATA && !ctrl_q[CB_EN]) |=> $stable(crc_q));

  // R3: seed write lands in the state next cycle
  assert_seed_load_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == REG_SEED) |=>
      (crc_q == ($past(wr_data[31:0]) & width_mask($past(mode)))));

  // R12: reading the checksum never disturbs the state
  assert_read_keeps_state_R12: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en) |=> $stable(crc_q));

  // R13: checksum bits above the active width read zero
  assert_csum_upper_zero_R13: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == REG_CSUM) |=>
      ((rd_data[31:0] & ~width_mask($past(mode))) == 32'd0));

endmodule

// File: tb/crcgen_top_tb_top.sv
module crcgen_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0, wr_size = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  crcgen_top dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_size(wr_size), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  localparam int NV = 8;
  localparam logic [31:0] TV_CTRL [NV] = '{
    32'hC000_0001, 32'hCB00_0001, 32'h0000_0001, 32'h8400_0001,
    32'h4000_0001, 32'h4200_0001, 32'h0F00_0001, 32'h8800_0001};
  localparam logic [31:0] TV_SEED [NV] = '{
    32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'h0000_0000,
    32'h0000_0000, 32'h0000_00FF, 32'h0000_1D0F, 32'h0000_FFFF};
  localparam logic [31:0] TV_DATA [NV] = '{
    32'h3433_3231, 32'h3433_3231, 32'h0000_3231, 32'hDEAD_BEEF,
    32'h0000_00C3, 32'h1234_5678, 32'h0000_00A5, 32'hCAFE_1234};
  localparam logic [1:0] TV_SIZE [NV] = '{
    2'd2, 2'd2, 2'd1, 2'd2, 2'd0, 2'd2, 2'd0, 2'd1};

  function automatic logic [31:0] model(logic [31:0] ctrl, logic [31:0] seed,
                                        logic [31:0] data, logic [1:0] size);
    int w, n;
    logic [31:0] p, s, r;
    logic [7:0] b, bb;
    case (ctrl[31:30])
      2'd0: begin w = 16; p = 32'h1021; end
      2'd1: begin w = 8;  p = 32'h07; end
      2'd2: begin w = 16; p = 32'h8005; end
      default: begin w = 32; p = 32'h04C11DB7; end
    endcase
    n = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
    s = seed;
    if (w < 32) s = s % (32'd1 << w);
    for (int i = 0; i < n; i++) begin
      b = data[i*8 +: 8];
      if (ctrl[26]) b = ~b;
      bb = b;
      if (ctrl[24]) for (int j = 0; j < 8; j++) bb[j] = b[7-j];
      for (int k = 7; k >= 0; k--) begin
        logic msb;
        msb = s[w-1];
        s = s << 1;
        if (w < 32) s = s % (32'd1 << w);
        if (msb ^ bb[k]) s = s ^ p;
      end
    end
    if (ctrl[27]) begin
      s = ~s;
      if (w < 32) s = s % (32'd1 << w);
    end
    if (ctrl[25]) begin
      r = '0;
      for (int j = 0; j < w; j++) r[j] = s[w-1-j];
      s = r;
    end
    return s;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d, logic [1:0] sz);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_size = sz;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R14 reset state
    rd(2'd0, v); check("R14 ctrl", v, 32'h0);
    rd(2'd1, v); check("R14 seed", v, 32'h0);
    rd(2'd3, v); check("R14 csum", v, 32'h0);

    // R1 register map and readback
    wr(2'd0, 32'hFFFF_FFFF, 2'd0);
    rd(2'd0, v); check("R1 ctrl keep mask", v, 32'hCF00_0001);
    wr(2'd1, 32'h1234_ABCD, 2'd0);
    rd(2'd1, v); check("R1 seed readback", v, 32'h1234_ABCD);
    rd(2'd2, v); check("R1 data port reads zero", v, 32'h0);

    // Table of vectors against the model
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, TV_CTRL[i], 2'd0);
      wr(2'd1, TV_SEED[i], 2'd0);
      wr(2'd2, TV_DATA[i], TV_SIZE[i]);
      rd(2'd3, v);
      check($sformatf("R5 R6 R7 R8 R9 R10 R11 R12 R13 vector %0d", i), v,
            model(TV_CTRL[i], TV_SEED[i], TV_DATA[i], TV_SIZE[i]));
    end

    // R5..R8 single-byte polynomial checks
    wr(2'd0, 32'hC000_0001, 2'd0); wr(2'd1, 32'h0, 2'd0); wr(2'd2, 32'h01, 2'd0);
    rd(2'd3, v); check("R5 crc32 poly", v, 32'h04C1_1DB7);
    wr(2'd0, 32'h8000_0001, 2'd0); wr(2'd1, 32'h0, 2'd0); wr(2'd2, 32'h01, 2'd0);
    rd(2'd3, v); check("R6 crc16 poly", v, 32'h0000_8005);
    wr(2'd0, 32'h0000_0001, 2'd0); wr(2'd1, 32'h0, 2'd0); wr(2'd2, 32'h01, 2'd0);
    rd(2'd3, v); check("R7 ccitt poly", v, 32'h0000_1021);
    wr(2'd0, 32'h4000_0001, 2'd0); wr(2'd1, 32'h0, 2'd0); wr(2'd2, 32'h01, 2'd0);
    rd(2'd3, v); check("R8 crc8 poly", v, 32'h0000_0007);

    // R9 size truncation: only lane 0 used
    wr(2'd1, 32'h0, 2'd0); wr(2'd2, 32'hAAAA_AA01, 2'd0);
    rd(2'd3, v); check("R9 one byte only", v, 32'h07);
    // R9 two writes vs one four-byte write
    wr(2'd0, 32'hC000_0001, 2'd0); wr(2'd1, 32'hFFFF_FFFF, 2'd0);
    wr(2'd2, 32'h0000_3231, 2'd1); wr(2'd2, 32'h0000_3433, 2'd1);
    rd(2'd3, v); check("R9 split writes", v,
                       model(32'hC000_0001, 32'hFFFF_FFFF, 32'h3433_3231, 2'd2));

    // R10 input complement: ~0xFE = 0x01
    wr(2'd0, 32'h4400_0001, 2'd0); wr(2'd1, 32'h0, 2'd0); wr(2'd2, 32'hFE, 2'd0);
    rd(2'd3, v); check("R10 input invert", v, 32'h07);
    // R11 per-byte reverse: 0x80 -> 0x01, lane 1 stays per-byte
    wr(2'd0, 32'h4100_0001, 2'd0); wr(2'd1, 32'h0, 2'd0); wr(2'd2, 32'h80, 2'd0);
    rd(2'd3, v); check("R11 input byte reverse", v, 32'h07);

    // R12 output complement, state untouched
    wr(2'd0, 32'h4800_0001, 2'd0); wr(2'd1, 32'h0, 2'd0); wr(2'd2, 32'h01, 2'd0);
    rd(2'd3, v); check("R12 output invert", v, 32'h0000_00F8);
    rd(2'd3, v2); check("R12 repeat read", v2, 32'h0000_00F8);
    wr(2'd0, 32'h4000_0001, 2'd0);
    rd(2'd3, v); check("R12 state unchanged", v, 32'h07);

    // R13 output reverse within width
    wr(2'd0, 32'h4200_0001, 2'd0);
    rd(2'd3, v); check("R13 crc8 reverse", v, 32'h0000_00E0);
    wr(2'd0, 32'h8200_0001, 2'd0); wr(2'd1, 32'h0, 2'd0); wr(2'd2, 32'h01, 2'd0);
    rd(2'd3, v); check("R13 crc16 reverse", v, 32'h0000_A001);

    // R2 enable clear
    wr(2'd0, 32'h4000_0000, 2'd0); wr(2'd1, 32'h5A, 2'd0); wr(2'd2, 32'h01, 2'd0);
    rd(2'd3, v); check("R2 disabled write", v, 32'h5A);

    // R3 seed masked to width
    wr(2'd1, 32'h1234_56C3, 2'd0);
    rd(2'd3, v); check("R3 seed masked", v, 32'hC3);

    // R4 reload with new mode
    wr(2'd0, 32'h8000_0001, 2'd0); wr(2'd2, 32'h01, 2'd0);
    wr(2'd0, 32'h8000_0003, 2'd0);
    rd(2'd3, v); check("R4 reload", v, 32'h0000_56C3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule